// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation buffer. It maps a virtual page number to a physical page number and three permission bits. Every entry also holds the identifier of the address space that owns it. Translations from several processes can therefore stay resident at the same time, and switching between processes does not require clearing the buffer. A lookup compares the requested page and the active process identifier against all entries at once and answers in the same cycle. The answer is one of three results: a hit, a protection fault, or a miss.

A page walker or system software loads translations through a fill stream that uses a valid/ready handshake. The buffer offers two ways to remove entries. A global flush clears every entry. A targeted invalidate removes one translation when its page-table entry changes. A fill goes to the first free slot it can use. When every slot is occupied, a round-robin pointer picks the slot to overwrite.

Top module: `pgmap_tlb`

## Requirements
- R1: While reset is held and directly after reset, every entry is empty, every lookup reports a miss with `lk_hit`=0 and `lk_fault`=0, and `lk_ppn` and `lk_rights` read zero.
- R2: A lookup matches an entry only when the entry is valid, its page number equals `lk_vpn` and its process identifier equals `lk_pid`. On a match, `lk_ppn` and `lk_rights` show that entry's stored values. On a miss, they read zero.
- R3: The permission field is encoded as follows: bit 0 allows read, bit 1 allows write and bit 2 allows execute. The access type `lk_kind` is encoded as 0 for read, 1 for write, 2 for execute and 3 for reserved, and a reserved access is never allowed. A match whose access is allowed raises `lk_hit`. A match whose access is not allowed raises `lk_fault` and keeps `lk_hit` low. The two outputs are never high together.
- R4: The lookup path is combinational. A fill accepted at a clock edge becomes visible to lookups from that edge onwards, and is not visible during the cycle in which it is offered.
- R5: An accepted fill chooses its slot in this order of priority. First, it rewrites a valid entry that has the same page number and process identifier, so that no key is ever held twice. Otherwise it takes the lowest-numbered empty slot. Otherwise it takes the slot named by the round-robin pointer. The pointer then steps by one and wraps from ENTRIES-1 to 0. The pointer changes only in this last case.
- R6: When `flush_req` is high at a clock edge, every entry becomes invalid at that edge. The round-robin pointer is left unchanged.
- R7: When `inv_req` is high at a clock edge, only the entry whose page number and process identifier both equal `inv_vpn` and `inv_pid` is removed. When no entry matches, nothing changes.
- R8: Flush takes priority over invalidate, and invalidate takes priority over fill. `fill_ready` is low in any cycle with `flush_req` or `inv_req` high, and high otherwise. A fill is taken only when `fill_valid` and `fill_ready` are both high. A fill offered while `fill_ready` is low is not taken, and the source must hold it and offer it again.
- R9: With `lk_valid` low, `lk_hit`, `lk_fault`, `lk_ppn` and `lk_rights` all read zero, whatever the other lookup inputs are.
- R10: Entries with the same page number but different process identifiers can be resident together. Each one answers only lookups made with its own identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_pid | input | PID_W | Active process identifier |
| lk_kind | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_fault | output | 1 | Translation found but access not allowed |
| lk_ppn | output | PPN_W | Physical page number of the matching entry |
| lk_rights | output | 3 | Permission bits of the matching entry |
| fill_valid | input | 1 | A fill is offered |
| fill_ready | output | 1 | A fill can be accepted this cycle |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_pid | input | PID_W | Process identifier of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_rights | input | 3 | Permission bits of the fill |
| flush_req | input | 1 | Clear every entry at the next edge |
| inv_req | input | 1 | Remove the entry that matches `inv_vpn` and `inv_pid` |
| inv_vpn | input | VPN_W | Page number to invalidate |
| inv_pid | input | PID_W | Process identifier to invalidate |

## Verification
The assertions check on every cycle that hit and fault never occur together and that no two entries ever match the same lookup key. They also check that a flush leaves no valid entry, that an accepted fill lands with the offered data, that a matched invalidate removes its entry, and that the round-robin pointer moves only when a fill is accepted. Other properties can only be shown by the bench's scenarios, where a behavioural model runs alongside the design. These include which slot a fill picks as the buffer fills up and then wraps, whether a duplicate key is rewritten in place, whether same-page entries from different processes are kept apart, and which command wins when requests collide.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int RIGHTS_W = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // bit 0 read, bit 1 write, bit 2 execute; reserved kind never allowed
  function automatic logic rights_allow(input logic [RIGHTS_W-1:0] rt, input logic [1:0] kind);
    logic ok;
    case (acc_kind_e'(kind))
      ACC_READ:  ok = rt[0];
      ACC_WRITE: ok = rt[1];
      ACC_EXEC:  ok = rt[2];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/pgmap_match.sv
module pgmap_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     ent_valid,
  input  logic [VPN_W-1:0] ent_vpn [N],
  input  logic [PID_W-1:0] ent_pid [N],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [PID_W-1:0] key_pid,
  output logic [N-1:0]     hit_vec,
  output logic             hit_any,
  output logic [IDX_W-1:0] hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) && (ent_pid[g] == key_pid);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/pgmap_alloc.sv
module pgmap_alloc #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ent_valid,
  input  logic             dup_any,
  input  logic [IDX_W-1:0] dup_idx,
  input  logic             take,
  output logic [IDX_W-1:0] slot
);
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  logic             use_rr;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
  end

  assign use_rr = !dup_any && !free_any;
  assign slot   = dup_any ? dup_idx : (free_any ? free_idx : rr_ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (take && use_rr) begin
      rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  a_r5_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(rr_ptr));
endmodule

// File: rtl/pgmap_store.sv
module pgmap_store #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PPN_W = 20,
  parameter int RT_W  = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             inv_en,
  input  logic [N-1:0]     inv_vec,
  input  logic             inv_any,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [RT_W-1:0]  wr_rights,
  output logic [N-1:0]     ent_valid,
  output logic [VPN_W-1:0] ent_vpn [N],
  output logic [PID_W-1:0] ent_pid [N],
  output logic [PPN_W-1:0] ent_ppn [N],
  output logic [RT_W-1:0]  ent_rights [N]
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[g]  <= 1'b0;
        ent_vpn[g]    <= '0;
        ent_pid[g]    <= '0;
        ent_ppn[g]    <= '0;
        ent_rights[g] <= '0;
      end else if (flush) begin
        ent_valid[g] <= 1'b0;
      end else if (inv_en) begin
        if (inv_vec[g]) ent_valid[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        ent_valid[g]  <= 1'b1;
        ent_vpn[g]    <= wr_vpn;
        ent_pid[g]    <= wr_pid;
        ent_ppn[g]    <= wr_ppn;
        ent_rights[g] <= wr_rights;
      end
    end
  end

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_valid == '0));

  a_r7_inv_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !flush && inv_any) |=> !ent_valid[$past(inv_idx)]);

  a_r5_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && !inv_en) |=>
      (ent_valid[$past(wr_idx)] && ent_ppn[$past(wr_idx)] == $past(wr_ppn)
       && ent_vpn[$past(wr_idx)] == $past(wr_vpn)));
endmodule

// File: rtl/pgmap_tlb.sv
module pgmap_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int RT_W   = pgmap_pkg::RIGHTS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [1:0]       lk_kind,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [2:0]       lk_rights,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [2:0]       fill_rights,
  input  logic             flush_req,
  input  logic             inv_req,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [PID_W-1:0] inv_pid
);
  import pgmap_pkg::*;

  logic [ENTRIES-1:0] ent_valid;
  logic [VPN_W-1:0]   ent_vpn    [ENTRIES];
  logic [PID_W-1:0]   ent_pid    [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn    [ENTRIES];
  logic [RT_W-1:0]    ent_rights [ENTRIES];

  logic [ENTRIES-1:0] lk_vec, fl_vec, iv_vec;
  logic               lk_any, fl_any, iv_any;
  logic [IDX_W-1:0]   lk_idx, fl_idx, iv_idx;
  logic [IDX_W-1:0]   slot;
  logic               fill_take;
  logic               lk_match;
  logic               lk_allow;

  pgmap_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_cmp (
    .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_pid(ent_pid),
    .key_vpn(lk_vpn), .key_pid(lk_pid),
    .hit_vec(lk_vec), .hit_any(lk_any), .hit_idx(lk_idx));

  pgmap_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_fl_cmp (
    .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_pid(ent_pid),
    .key_vpn(fill_vpn), .key_pid(fill_pid),
    .hit_vec(fl_vec), .hit_any(fl_any), .hit_idx(fl_idx));

  pgmap_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_iv_cmp (
    .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_pid(ent_pid),
    .key_vpn(inv_vpn), .key_pid(inv_pid),
    .hit_vec(iv_vec), .hit_any(iv_any), .hit_idx(iv_idx));

  assign fill_ready = !flush_req && !inv_req;
  assign fill_take  = fill_valid && fill_ready;

  pgmap_alloc #(.N(ENTRIES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid),
    .dup_any(fl_any), .dup_idx(fl_idx), .take(fill_take), .slot(slot));

  pgmap_store #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W), .RT_W(RT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_req),
    .inv_en(inv_req), .inv_vec(iv_vec), .inv_any(iv_any), .inv_idx(iv_idx),
    .wr_en(fill_take), .wr_idx(slot), .wr_vpn(fill_vpn), .wr_pid(fill_pid),
    .wr_ppn(fill_ppn), .wr_rights(fill_rights),
    .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_pid(ent_pid),
    .ent_ppn(ent_ppn), .ent_rights(ent_rights));

  assign lk_match  = lk_valid && lk_any;
  assign lk_allow  = rights_allow(ent_rights[lk_idx], lk_kind);
  assign lk_hit    = lk_match && lk_allow;
  assign lk_fault  = lk_match && !lk_allow;
  assign lk_ppn    = lk_match ? ent_ppn[lk_idx] : '0;
  assign lk_rights = lk_match ? ent_rights[lk_idx] : '0;

  a_r3_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  a_r5_unique_key: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));

  a_r8_flush_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && fill_valid) |=> !$past(fill_take));
endmodule

// File: tb/sim_pgmap_tlb.sv
module sim_pgmap_tlb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        lk_valid = 0;
  logic [19:0] lk_vpn = 0;
  logic [7:0]  lk_pid = 0;
  logic [1:0]  lk_kind = 0;
  logic        lk_hit, lk_fault, fill_ready;
  logic [19:0] lk_ppn;
  logic [2:0]  lk_rights;
  logic        fill_valid = 0;
  logic [19:0] fill_vpn = 0;
  logic [7:0]  fill_pid = 0;
  logic [19:0] fill_ppn = 0;
  logic [2:0]  fill_rights = 0;
  logic        flush_req = 0;
  logic        inv_req = 0;
  logic [19:0] inv_vpn = 0;
  logic [7:0]  inv_pid = 0;

  pgmap_tlb u0 (.*);

  bit m_v[N];
  int m_vpn[N], m_pid[N], m_ppn[N], m_rt[N];
  int m_ptr;
  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  function automatic int find(int vpn, int pid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
    return -1;
  endfunction

  task automatic step(string tag);
    int e, eh, ef, ep, er, er_dy;
    #2;
    e = lk_valid ? find(lk_vpn, lk_pid) : -1;
    eh = 0; ef = 0; ep = 0; er = 0;
    if (e >= 0) begin
      int ok;
      ok = (lk_kind == 0) ? m_rt[e] & 1 : (lk_kind == 1) ? (m_rt[e] >> 1) & 1 :
           (lk_kind == 2) ? (m_rt[e] >> 2) & 1 : 0;
      eh = ok; ef = !ok; ep = m_ppn[e]; er = m_rt[e];
    end
    er_dy = (!flush_req && !inv_req);
    n_run++;
    if (lk_hit !== eh[0] || lk_fault !== ef[0] || lk_ppn !== ep[19:0] ||
        lk_rights !== er[2:0] || fill_ready !== er_dy[0]) begin
      n_fail++;
      $display("FAIL %s: got hit=%0b fault=%0b ppn=%0h rt=%0h rdy=%0b exp hit=%0d fault=%0d ppn=%0h rt=%0h rdy=%0d",
               tag, lk_hit, lk_fault, lk_ppn, lk_rights, fill_ready, eh, ef, ep, er, er_dy);
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_ptr = 0;
    end else if (flush_req) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (inv_req) begin
      e = find(inv_vpn, inv_pid);
      if (e >= 0) m_v[e] = 0;
    end else if (fill_valid) begin
      e = find(fill_vpn, fill_pid);
      if (e < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) e = i;
      if (e < 0) begin e = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_v[e] = 1; m_vpn[e] = fill_vpn; m_pid[e] = fill_pid;
      m_ppn[e] = fill_ppn; m_rt[e] = fill_rights;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    fill_valid = 0; flush_req = 0; inv_req = 0;
  endtask

  task automatic look(int vpn, int pid, int kind, string tag);
    idle();
    lk_valid = 1; lk_vpn = vpn[19:0]; lk_pid = pid[7:0]; lk_kind = kind[1:0];
    step(tag);
  endtask

  task automatic fill(int vpn, int pid, int ppn, int rt, string tag);
    idle();
    fill_valid = 1; fill_vpn = vpn[19:0]; fill_pid = pid[7:0];
    fill_ppn = ppn[19:0]; fill_rights = rt[2:0];
    step(tag);
    fill_valid = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_ptr = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    @(negedge clk);
    lk_valid = 1; lk_vpn = 20'h12; lk_pid = 1;
    step("R1"); step("R1");
    rst_n = 1;
    look(20'h12, 1, 0, "R1");

    // R4: fill not visible in its own cycle, visible after
    lk_valid = 1; lk_vpn = 20'h40; lk_pid = 3; lk_kind = 0;
    fill_valid = 1; fill_vpn = 20'h40; fill_pid = 3; fill_ppn = 20'hABCDE; fill_rights = 3'b111;
    step("R4");
    look(20'h40, 3, 0, "R4");
    fill(20'h41, 3, 20'h11111, 3'b001, "R2");
    fill(20'h42, 3, 20'h22222, 3'b110, "R2");
    look(20'h41, 3, 0, "R2");
    look(20'h42, 3, 2, "R2");
    look(20'h43, 3, 0, "R2");
    // R3 rights
    look(20'h41, 3, 1, "R3");
    look(20'h41, 3, 2, "R3");
    look(20'h42, 3, 0, "R3");
    look(20'h42, 3, 1, "R3");
    look(20'h40, 3, 3, "R3");
    // R10 pid separation
    look(20'h40, 4, 0, "R10");
    fill(20'h40, 4, 20'h0F0F0, 3'b001, "R10");
    look(20'h40, 4, 0, "R10");
    look(20'h40, 3, 0, "R10");
    // R9
    lk_valid = 0; lk_vpn = 20'h40; lk_pid = 3; step("R9");
    // R5 duplicate rewrite
    fill(20'h41, 3, 20'h33333, 3'b011, "R5");
    look(20'h41, 3, 1, "R5");
    // R7 invalidate
    idle(); inv_req = 1; inv_vpn = 20'h41; inv_pid = 9; step("R7");
    look(20'h41, 3, 0, "R7");
    idle(); inv_req = 1; inv_vpn = 20'h41; inv_pid = 3; step("R7");
    look(20'h41, 3, 0, "R7");
    look(20'h42, 3, 2, "R7");
    // R8 priority
    idle(); inv_req = 1; inv_vpn = 20'h42; inv_pid = 3;
    fill_valid = 1; fill_vpn = 20'h50; fill_pid = 3; fill_ppn = 20'h5; fill_rights = 1;
    step("R8");
    look(20'h50, 3, 0, "R8");
    look(20'h42, 3, 2, "R8");
    idle(); flush_req = 1; inv_req = 1;
    fill_valid = 1; fill_vpn = 20'h51; fill_pid = 3; fill_ppn = 20'h6; fill_rights = 1;
    step("R8");
    // R6 flush result
    look(20'h40, 3, 0, "R6");
    look(20'h51, 3, 0, "R6");
    look(20'h40, 4, 0, "R6");
    // R5 fill to full then round-robin
    for (int i = 0; i < N; i++) fill(100 + i, 1, 1000 + i, 3'b001, "R5");
    fill(200, 1, 2000, 3'b001, "R5");
    look(100, 1, 0, "R5");
    look(200, 1, 0, "R5");
    fill(201, 1, 2001, 3'b001, "R5");
    look(101, 1, 0, "R5");
    look(102, 1, 0, "R5");
    idle(); inv_req = 1; inv_vpn = 105; inv_pid = 1; step("R7");
    fill(202, 1, 2002, 3'b001, "R5");
    fill(203, 1, 2003, 3'b001, "R5");
    look(102, 1, 0, "R5");
    look(106, 1, 0, "R5");
    look(202, 1, 0, "R5");
    // random mix against the model
    for (int k = 0; k < 2000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      idle();
      lk_valid = ($urandom_range(0, 9) != 0);
      lk_vpn = 20'($urandom_range(0, 23)); lk_pid = 8'($urandom_range(0, 2));
      lk_kind = 2'($urandom_range(0, 3));
      fill_valid = (r < 55);
      fill_vpn = 20'($urandom_range(0, 23)); fill_pid = 8'($urandom_range(0, 2));
      fill_ppn = 20'($urandom); fill_rights = 3'($urandom_range(0, 7));
      inv_req = (r >= 55 && r < 70) || (r < 3);
      inv_vpn = 20'($urandom_range(0, 23)); inv_pid = 8'($urandom_range(0, 2));
      flush_req = (r == 99);
      step("R5");
    end
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule